// File: doc/BRIEF.md
# Multi-Slave SPI Master with Per-Slave Clock Mode

This block is a full-duplex SPI master for a bus with several slave devices. Each slave has its own active-low select line. All slaves share one serial clock, one master-to-slave data line and one slave-to-master data line. A small per-slave table holds three settings for each slave: the clock polarity, the clock phase and the character length, which can be from 4 to 16 bits. The table is loaded through a simple write port.

A transfer request gives a slave index and a transmit word. The master reads that slave's entry from the table. It moves the serial clock to the slave's idle level while every select is still high, and only then asserts the target select. It shifts the word out most significant bit first while it shifts the reply in, releases the select, and presents the received word with a one-cycle done strobe. No acknowledgement is ever expected from the slave, so a transfer always runs to its end. Consecutive transfers to slaves with different modes therefore switch polarity and phase only between transfers, while the bus is deselected.

Top module: `spi_multi_master`

## Requirements
- R1: After reset every select output is high, the serial clock and MOSI are low, and busy and done are low.
- R2: During a transfer exactly one select is low, the one whose index was requested, and it stays low without change until the transfer ends.
- R3: A configuration write stores polarity, phase and length for the addressed slave. Each transfer uses the stored settings of its target slave.
- R4: Before the target select falls, the serial clock already rests at the target polarity (0 = idle low, 1 = idle high). While the select is low the clock makes exactly 2×length edges, and it is back at its idle level when the select rises.
- R5: The low `length` bits of the transmit word leave on MOSI most significant bit first. The last `length` bits sampled from MISO are returned right-aligned on the receive output, with all bits above `length` zero.
- R6: With phase 0, MOSI holds the first bit before the first clock edge, and data is sampled on odd edges (1st, 3rd, …) and changed on even edges. With phase 1, data changes on odd edges and is sampled on even edges.
- R7: A stored length below 4 acts as 4, and a stored length above 16 acts as 16.
- R8: Each serial clock level lasts CLK_HALF system clock cycles, so the span from the first to the last clock edge of a transfer is (2×length − 1)×CLK_HALF cycles.
- R9: Busy is high from the cycle after an accepted request until done. Done is a single-cycle pulse, with busy low and all selects high. A request made while busy is ignored and starts no later transfer.
- R10: A transfer completes whatever MISO does, including a line stuck at 0 or stuck at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Slave whose settings are written |
| cfg_cpol_i | input | 1 | Clock idle level for that slave |
| cfg_cpha_i | input | 1 | Clock phase for that slave |
| cfg_len_i | input | 5 | Character length in bits (4 to 16 after clamping) |
| req_i | input | 1 | Transfer request, taken when not busy |
| req_idx_i | input | IDX_W | Target slave of the request |
| req_data_i | input | 16 | Transmit word, right-aligned |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rx_data_o | output | 16 | Received word, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Master-to-slave data |
| ss_no | output | N_SLV | Active-low slave selects |
| miso_i | input | 1 | Slave-to-master data |

## Verification
The bench builds the block with four slaves and CLK_HALF = 2. With four slaves, each of the four polarity/phase combinations can sit in its own table entry, so back-to-back transfers force a mode change on almost every request. With a half period of two cycles, the select-to-edge spacing and the edge-to-edge spacing can be told apart from a single-cycle slip. Lengths of 4, 8, 12 and 16 cover both ends of the legal range. Further writes of 2 and 20 reach the clamping on both sides.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 5;
  localparam int EC_W   = LEN_W + 1;
  localparam int LEN_MIN = 4;
  localparam int LEN_MAX = DATA_W;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic [LEN_W-1:0] len;
  } slv_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MODE  = 2'd1,
    ST_SHIFT = 2'd2
  } eng_st_t;
endpackage

// File: rtl/spi_mode_table.sv
module spi_mode_table
  import spi_mst_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [IDX_W-1:0] ridx_i,
  output slv_mode_t        mode_o
);
  slv_mode_t             wr_mode;
  slv_mode_t [N_SLV-1:0] tbl_q;

  // clamp length into the legal range on write
  always_comb begin
    wr_mode.cpol = cpol_i;
    wr_mode.cpha = cpha_i;
    if (len_i < LEN_W'(LEN_MIN))      wr_mode.len = LEN_W'(LEN_MIN);
    else if (len_i > LEN_W'(LEN_MAX)) wr_mode.len = LEN_W'(LEN_MAX);
    else                              wr_mode.len = len_i;
  end

  for (genvar g = 0; g < N_SLV; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_q[g] <= '{cpol: 1'b0, cpha: 1'b0, len: LEN_W'(8)};
      end else if (we_i && widx_i == IDX_W'(g)) begin
        tbl_q[g] <= wr_mode;
      end
    end
  end

  always_comb begin
    mode_o = tbl_q[0];
    for (int i = 0; i < N_SLV; i++) begin
      if (ridx_i == IDX_W'(i)) mode_o = tbl_q[i];
    end
  end

  p_len_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o.len >= LEN_W'(LEN_MIN)) && (mode_o.len <= LEN_W'(LEN_MAX)));
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CLK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  if (CLK_HALF > 1) begin : g_gap
    p_tick_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_mst_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] tx_i,
  input  slv_mode_t         mode_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [N_SLV-1:0]  ss_no,
  input  logic              miso_i
);
  eng_st_t           st_q;
  logic [IDX_W-1:0]  idx_q;
  slv_mode_t         mode_q;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_q;
  logic [EC_W-1:0]   edge_cnt;
  logic              sclk_q, mosi_q, done_q;
  logic [N_SLV-1:0]  ss_q;
  logic              lead, samp, last;

  assign lead = !edge_cnt[0];           // next edge is odd numbered
  assign samp = lead ^ mode_q.cpha;
  assign last = edge_cnt == {mode_q.len, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      mode_q   <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_q     <= '0;
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
      ss_q     <= '1;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          idx_q    <= idx_i;
          mode_q   <= mode_i;
          tx_sr    <= tx_i << (LEN_W'(DATA_W) - mode_i.len);
          rx_sr    <= '0;
          edge_cnt <= '0;
          sclk_q   <= mode_i.cpol;  // new idle level while deselected
          mosi_q   <= 1'b0;
          st_q     <= ST_MODE;
        end
        ST_MODE: begin
          ss_q <= ~(N_SLV'(1) << idx_q);
          if (!mode_q.cpha) begin
            mosi_q <= tx_sr[DATA_W-1];
            tx_sr  <= tx_sr << 1;
          end
          st_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          if (last) begin
            ss_q   <= '1;
            mosi_q <= 1'b0;
            rx_q   <= rx_sr;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (samp) begin
              rx_sr <= {rx_sr[DATA_W-2:0], miso_i};
            end else begin
              mosi_q <= tx_sr[DATA_W-1];
              tx_sr  <= tx_sr << 1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = st_q == ST_SHIFT;
  assign busy_o = st_q != ST_IDLE;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign ss_no  = ss_q;

  p_one_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ss_q) <= 1);
  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&$past(ss_q)) && !(&ss_q)) |-> (ss_q == $past(ss_q)));
  p_idle_at_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&$past(ss_q)) && !(&ss_q)) |-> (sclk_q == mode_q.cpol));
  p_idle_at_rel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&$past(ss_q)) && (&ss_q)) |-> (sclk_q == mode_q.cpol));
  p_edge_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_cnt <= {mode_q.len, 1'b0});
  p_done_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((&ss_q) && !busy_o));
  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(idx_q));
endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
  import spi_mst_pkg::*;
#(
  parameter int N_SLV    = 4,
  parameter int CLK_HALF = 2,
  localparam int IDX_W   = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              req_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [N_SLV-1:0]  ss_no,
  input  logic              miso_i
);
  slv_mode_t req_mode;
  logic      run, tick;

  spi_mode_table #(.N_SLV(N_SLV), .IDX_W(IDX_W)) i_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .widx_i (cfg_idx_i),
    .cpol_i (cfg_cpol_i),
    .cpha_i (cfg_cpha_i),
    .len_i  (cfg_len_i),
    .ridx_i (req_idx_i),
    .mode_o (req_mode)
  );

  spi_clk_div #(.CLK_HALF(CLK_HALF)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_shift_eng #(.N_SLV(N_SLV), .IDX_W(IDX_W)) i_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_i),
    .idx_i   (req_idx_i),
    .tx_i    (req_data_i),
    .mode_i  (req_mode),
    .tick_i  (tick),
    .run_o   (run),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rx_o    (rx_data_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .ss_no   (ss_no),
    .miso_i  (miso_i)
  );
endmodule

// File: tb/test_spi_multi_master.sv
`timescale 1ns/1ps
module test_spi_multi_master;
  localparam int NS = 4;
  localparam int HALF = 2;
  localparam int NV = 8;

  logic        clk, rst_n;
  logic        cfg_we, cfg_cpol, cfg_cpha;
  logic [1:0]  cfg_idx, req_idx;
  logic [4:0]  cfg_len;
  logic        req;
  logic [15:0] req_data, rx_data;
  logic        busy, done, sclk, mosi, miso;
  logic [NS-1:0] ss_n;

  spi_multi_master #(.N_SLV(NS), .CLK_HALF(HALF)) i_spi_multi_master (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_cpol_i(cfg_cpol), .cfg_cpha_i(cfg_cpha), .cfg_len_i(cfg_len),
    .req_i(req), .req_idx_i(req_idx), .req_data_i(req_data),
    .busy_o(busy), .done_o(done), .rx_data_o(rx_data),
    .sclk_o(sclk), .mosi_o(mosi), .ss_no(ss_n), .miso_i(miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // {idx[1:0], tx[15:0], reply[15:0]}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 16'h00A5, 16'h003C},
    {2'd2, 16'hBEEF, 16'h1234},
    {2'd1, 16'h0009, 16'h0006},
    {2'd3, 16'h0ABC, 16'h0F0F},
    {2'd0, 16'hFFFF, 16'h0000},
    {2'd3, 16'h1555, 16'hFFFF},
    {2'd2, 16'h0000, 16'hFFFF},
    {2'd1, 16'hFFF6, 16'h000A}
  };

  // bench copy of slave settings, from requirements R3/R7
  logic       b_cpol [NS];
  logic       b_cpha [NS];
  int         b_len  [NS];

  // behavioural slave
  logic [15:0] s_reply, s_sr, s_rx;
  int          s_idx, s_edges, s_nsel, s_len;
  logic        s_cpha, s_act, s_lvl_ok, s_end_lvl, s_onehot;
  longint      s_t_first, s_t_last;
  logic [NS-1:0] prev_ss;
  logic        prev_sclk;

  initial begin
    s_act = 0; s_nsel = 0; s_edges = 0; s_rx = '0; s_sr = '0; s_idx = -1;
    s_reply = '0; miso = 1'b0; prev_ss = '1; prev_sclk = 1'b0;
    s_lvl_ok = 0; s_end_lvl = 0; s_onehot = 0; s_cpha = 0; s_len = 8;
    s_t_first = 0; s_t_last = 0;
  end

  always @(ss_n, sclk) begin
    if (ss_n !== prev_ss) begin
      if (ss_n != '1 && !s_act) begin
        s_act = 1; s_nsel++;
        s_onehot = ($countones(~ss_n) == 1);
        s_idx = -1;
        for (int i = 0; i < NS; i++) if (!ss_n[i]) s_idx = i;
        if (s_idx < 0) s_idx = 0;
        s_lvl_ok = (sclk == b_cpol[s_idx]);
        s_cpha = b_cpha[s_idx]; s_len = b_len[s_idx];
        s_edges = 0; s_rx = '0;
        s_sr = 16'(s_reply << (16 - s_len));
        if (!s_cpha) begin miso = s_sr[15]; s_sr = {s_sr[14:0], 1'b0}; end
      end else if (ss_n == '1 && s_act) begin
        s_act = 0; s_end_lvl = sclk;
      end
      prev_ss = ss_n;
    end
    if (sclk !== prev_sclk) begin
      if (s_act) begin
        s_edges++;
        if (s_edges == 1) s_t_first = $time;
        s_t_last = $time;
        if ((s_edges % 2 == 1) ^ s_cpha) s_rx = {s_rx[14:0], mosi};
        else begin miso = s_sr[15]; s_sr = {s_sr[14:0], 1'b0}; end
      end
      prev_sclk = sclk;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int clamp_len(input int l);
    if (l < 4) return 4;
    if (l > 16) return 16;
    return l;
  endfunction

  function automatic logic [15:0] msk(input int l);
    return 16'((32'd1 << l) - 1);
  endfunction

  task automatic do_cfg(input int idx, input logic cp, input logic ph, input int len);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_cpol = cp; cfg_cpha = ph; cfg_len = 5'(len);
    @(negedge clk);
    cfg_we = 0;
    b_cpol[idx] = cp; b_cpha[idx] = ph; b_len[idx] = clamp_len(len);
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic xfer(input int idx, input logic [15:0] tx, input logic [15:0] rep);
    bit ok;
    int l, nsel0;
    l = b_len[idx];
    s_reply = rep; nsel0 = s_nsel;
    @(negedge clk);
    req = 1; req_idx = 2'(idx); req_data = tx;
    @(negedge clk);
    req = 0;
    chk("R9", "busy after request", 32'(busy), 32'd1);
    wait_done(ok);
    chk("R9", "done seen", 32'(ok), 32'd1);
    chk("R9", "busy low at done", 32'(busy), 32'd0);
    chk("R5", "rx word", 32'(rx_data), 32'(rep & msk(l)));
    chk("R5", "mosi word at slave", 32'(s_rx), 32'(tx & msk(l)));
    chk("R2", "one select per transfer", 32'(s_nsel - nsel0), 32'd1);
    chk("R2", "target select", 32'(s_idx), 32'(idx));
    chk("R2", "single select low", 32'(s_onehot), 32'd1);
    chk("R4", "idle level at select", 32'(s_lvl_ok), 32'd1);
    chk("R4", "idle level at release", 32'(s_end_lvl), 32'(b_cpol[idx]));
    chk("R4", "edge count", 32'(s_edges), 32'(2 * l));
    chk("R8", "edge span ns", 32'(s_t_last - s_t_first), 32'((2 * l - 1) * HALF * 8));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin b_cpol[i] = 0; b_cpha[i] = 0; b_len[i] = 8; end
    cfg_we = 0; cfg_idx = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_len = 0;
    req = 0; req_idx = 0; req_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "selects", 32'(ss_n), 32'hF);
    chk("R1", "sclk", 32'(sclk), 0);
    chk("R1", "mosi", 32'(mosi), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 per-slave modes, one of each polarity/phase pair (R6)
    do_cfg(0, 1'b0, 1'b0, 8);
    do_cfg(1, 1'b0, 1'b1, 4);
    do_cfg(2, 1'b1, 1'b0, 16);
    do_cfg(3, 1'b1, 1'b1, 12);

    // table walk: R3, R5, R6, R10 (reply 0000/FFFF stuck lines)
    for (int v = 0; v < NV; v++) begin
      xfer(int'(VEC[v][33:32]), VEC[v][31:16], VEC[v][15:0]);
    end

    // R7 clamp low and high
    do_cfg(0, 1'b1, 1'b1, 2);
    xfer(0, 16'h0007, 16'h0005);
    chk("R7", "short length as 4 edges", 32'(s_edges), 32'd8);
    do_cfg(0, 1'b0, 1'b1, 20);
    xfer(0, 16'hC3A5, 16'h5AC3);
    chk("R7", "long length as 16 edges", 32'(s_edges), 32'd32);

    // R9 request while busy is ignored
    begin
      bit ok;
      int nsel0;
      s_reply = 16'h0003; nsel0 = s_nsel;
      @(negedge clk);
      req = 1; req_idx = 2'd1; req_data = 16'h000C;
      @(negedge clk);
      req = 0;
      repeat (4) @(negedge clk);
      req = 1; req_idx = 2'd2; req_data = 16'h1111;
      @(negedge clk);
      req = 0;
      wait_done(ok);
      chk("R9", "first transfer done", 32'(ok), 32'd1);
      chk("R9", "target kept", 32'(s_idx), 32'd1);
      chk("R9", "rx of first", 32'(rx_data), 32'h3);
      chk("R9", "done is one cycle", 32'(done), 32'd1);
      @(negedge clk);
      chk("R9", "done pulse ends", 32'(done), 32'd0);
      repeat (10) @(negedge clk);
      chk("R9", "no second transfer", 32'(s_nsel - nsel0), 32'd1);
      chk("R9", "idle after ignored request", 32'(busy), 32'd0);
      chk("R9", "selects high", 32'(ss_n), 32'hF);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule